// File: doc/BRIEF.md
# Control-Track Pulse Timing Generator

This block times the control pulse written to a tape's control track. A free-running interval counter advances once every few system clocks and is restarted by a reference edge. In record mode the restart comes from the frame reference input. In rewrite mode it comes from the playback control input instead. Each restart opens a new period. Five compare slots, which software may write at any time, each mark a count at which a match strobe fires once in that period.

A small state machine shapes the output pulse. It has three states: `P_IDLE`, `P_HIGH` and `P_LOW`.
- It leaves `P_IDLE` on the first restart and goes to `P_HIGH`.
- It moves from `P_HIGH` to `P_LOW` when the selected slot matches.
- It returns from `P_LOW` (or re-enters `P_HIGH` from `P_HIGH`) on every restart.

At each restart the block latches a data-bit input. That bit chooses which slot ends the pulse: slot 0 gives the short width and slot 1 the long width.

Writing a slot takes effect in one of two ways:
- If the slot has not matched yet in the current period, the write takes effect at once and that period's match uses the new value.
- Once the slot has matched, the value is parked in a pending copy. It is installed at the next rising edge of the frame reference, in either mode.

Top module: `ctl_pulse_gen`

## Requirements
- R1: `count_o` increases by one every TICK_DIV clocks. If no restart arrives, it steps from all-ones to zero, and this wrap does not begin a new period.
- R2: With `rec_mode`=1, a rising edge on `ref_in` clears `count_o` to 0 and starts a period. A rising edge on `pb_in` leaves the count unaffected.
- R3: With `rec_mode`=0, a rising edge on `pb_in` clears `count_o` and starts a period. A rising edge on `ref_in` does not change the count.
- R4: `wr_sel` values 0 to 4 address slots 0 to 4, and larger values are ignored. A write to a slot that has not matched in the current period is used for that period's match.
- R5: When a slot's value equals the count, `match_o[slot]` is high for exactly one clock. That clock is the first one in which `count_o` shows the slot value plus one (modulo 2^CNT_W).
- R6: Each slot matches at most once per period, including across a counter wrap.
- R7: A write to a slot that has already matched in the current period does not affect later periods until a rising edge of `ref_in` installs it. This holds in either mode.
- R8: `pulse_o` goes high at each period start. It goes low in the cycle that slot 0 strobes if `data_bit` was 0 at the start, or slot 1 if it was 1, and stays low until the next start.
- R9: After reset, the count is 0, `pulse_o` is 0, all slots hold 0, and no strobe fires until the first period start.
- R10: A restart in mid-period cancels the matches still to come. All slots become eligible again against the new count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Slot write strobe |
| wr_sel | input | 3 | Slot index for the write |
| wr_data | input | CNT_W | Value written to the slot |
| rec_mode | input | 1 | 1 = record (restart on ref_in), 0 = rewrite (restart on pb_in) |
| ref_in | input | 1 | Asynchronous frame reference |
| pb_in | input | 1 | Asynchronous playback control input |
| data_bit | input | 1 | Pulse width select, latched at period start |
| pulse_o | output | 1 | Shaped control pulse |
| match_o | output | NUM_CMP | One-clock match strobes, one per slot |
| count_o | output | CNT_W | Interval counter value |

## Verification
The bench builds the block with CNT_W=8 and keeps TICK_DIV=4 and five slots. The narrow counter lets a full wrap run in about a thousand clocks, so the once-per-period rule can be checked across a wrap. It also keeps each period short enough to run several record and rewrite periods. In those periods the bench covers immediate writes, deferred writes, a mid-period restart, and both pulse widths.

// File: rtl/ctl_pkg.sv
package ctl_pkg;
    typedef enum logic [1:0] {
        P_IDLE = 2'd0,
        P_HIGH = 2'd1,
        P_LOW  = 2'd2
    } pulse_state_e;
endpackage

// File: rtl/ctl_tick_div.sv
module ctl_tick_div #(
    parameter int TICK_DIV = 4
) (
    input  logic clk,
    input  logic rst,
    output logic tick_o
);
    localparam int DW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
    localparam logic [DW-1:0] LAST = DW'(TICK_DIV - 1);

    logic [DW-1:0] div_q;

    always_ff @(posedge clk) begin
        if (rst || div_q == LAST) div_q <= '0;
        else                      div_q <= div_q + 1'b1;
    end

    assign tick_o = (div_q == LAST);

    // ticks never come back to back when the divider is wider than one
    assert_tick_spacing_R1: assert property (@(posedge clk) disable iff (rst)
        (TICK_DIV > 1) && tick_o |=> !tick_o);
endmodule

// File: rtl/ctl_edge_sync.sv
module ctl_edge_sync #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] async_i,
    output logic [N-1:0] rise_o
);
    for (genvar g = 0; g < N; g++) begin : g_sync
        logic s1, s2, s3;
        always_ff @(posedge clk) begin
            if (rst) begin
                s1 <= 1'b0;
                s2 <= 1'b0;
                s3 <= 1'b0;
            end else begin
                s1 <= async_i[g];
                s2 <= s1;
                s3 <= s2;
            end
        end
        assign rise_o[g] = s2 & ~s3;

        assert_rise_single_R2: assert property (@(posedge clk) disable iff (rst)
            rise_o[g] |=> !rise_o[g]);
    end
endmodule

// File: rtl/ctl_cmp_slot.sv
module ctl_cmp_slot #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run_i,
    input  logic             tick_i,
    input  logic             clr_i,
    input  logic             commit_i,
    input  logic [CNT_W-1:0] cnt_i,
    input  logic             wr_i,
    input  logic [CNT_W-1:0] wr_data_i,
    output logic             hit_o,
    output logic             match_o
);
    logic [CNT_W-1:0] active_q, pend_q;
    logic             pend_v_q, done_q;
    logic             defer;

    assign hit_o = run_i & tick_i & ~clr_i & ~done_q & (cnt_i == active_q);
    assign defer = (done_q & ~clr_i) | hit_o;

    always_ff @(posedge clk) begin
        if (rst) begin
            active_q <= '0;
            pend_q   <= '0;
            pend_v_q <= 1'b0;
            done_q   <= 1'b0;
            match_o  <= 1'b0;
        end else begin
            match_o <= hit_o;
            if (clr_i)      done_q <= 1'b0;
            else if (hit_o) done_q <= 1'b1;
            if (wr_i) begin
                if (defer) begin
                    pend_q   <= wr_data_i;
                    pend_v_q <= 1'b1;
                end else begin
                    active_q <= wr_data_i;
                    pend_v_q <= 1'b0;
                end
            end else if (commit_i && pend_v_q) begin
                active_q <= pend_q;
                pend_v_q <= 1'b0;
            end
        end
    end

    // a strobe is always accompanied by the period's matched flag
    assert_flag_with_strobe_R6: assert property (@(posedge clk) disable iff (rst)
        match_o |-> done_q);
    assert_strobe_single_R5: assert property (@(posedge clk) disable iff (rst)
        match_o |=> !match_o);
endmodule

// File: rtl/ctl_pulse_gen.sv
module ctl_pulse_gen
    import ctl_pkg::*;
#(
    parameter int CNT_W      = 16,
    parameter int NUM_CMP    = 5,
    parameter int TICK_DIV   = 4,
    parameter int SHORT_SLOT = 0,
    parameter int LONG_SLOT  = 1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               wr_en,
    input  logic [2:0]         wr_sel,
    input  logic [CNT_W-1:0]   wr_data,
    input  logic               rec_mode,
    input  logic               ref_in,
    input  logic               pb_in,
    input  logic               data_bit,
    output logic               pulse_o,
    output logic [NUM_CMP-1:0] match_o,
    output logic [CNT_W-1:0]   count_o
);
    localparam int REF_IDX = 0;
    localparam int PB_IDX  = 1;

    logic               tick;
    logic [1:0]         rise;
    logic               clr;
    logic               running;
    logic [CNT_W-1:0]   cnt_q;
    logic [NUM_CMP-1:0] hits;
    logic               sel_hit;
    logic               bit_q;
    pulse_state_e       state_q, state_d;

    ctl_tick_div #(.TICK_DIV(TICK_DIV)) u_div (
        .clk(clk), .rst(rst), .tick_o(tick)
    );

    ctl_edge_sync #(.N(2)) u_sync (
        .clk(clk), .rst(rst), .async_i({pb_in, ref_in}), .rise_o(rise)
    );

    assign clr     = rec_mode ? rise[REF_IDX] : rise[PB_IDX];
    assign running = (state_q != P_IDLE);

    always_ff @(posedge clk) begin
        if (rst)       cnt_q <= '0;
        else if (clr)  cnt_q <= '0;
        else if (tick) cnt_q <= cnt_q + 1'b1;
    end
    assign count_o = cnt_q;

    for (genvar s = 0; s < NUM_CMP; s++) begin : g_slot
        ctl_cmp_slot #(.CNT_W(CNT_W)) u_slot (
            .clk(clk), .rst(rst), .run_i(running), .tick_i(tick),
            .clr_i(clr), .commit_i(rise[REF_IDX]), .cnt_i(cnt_q),
            .wr_i(wr_en && (wr_sel == 3'(s))), .wr_data_i(wr_data),
            .hit_o(hits[s]), .match_o(match_o[s])
        );
    end

    assign sel_hit = bit_q ? hits[LONG_SLOT] : hits[SHORT_SLOT];

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= P_IDLE;
            bit_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            if (clr) bit_q <= data_bit;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            P_IDLE:  if (clr) state_d = P_HIGH;
            P_HIGH:  if (clr) state_d = P_HIGH;
                     else if (sel_hit) state_d = P_LOW;
            P_LOW:   if (clr) state_d = P_HIGH;
            default: state_d = P_IDLE;
        endcase
    end

    always_comb begin
        pulse_o = (state_q == P_HIGH);
    end

    assert_count_step_R1: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (count_o == '0) || (CNT_W'(count_o - $past(count_o)) <= CNT_W'(1)));
    assert_pulse_fall_R8: assert property (@(posedge clk) disable iff (rst)
        $fell(pulse_o) |-> (match_o != '0));
    assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (rst)
        (state_q == P_IDLE) |-> (match_o == '0));
endmodule

// File: tb/ctl_pulse_gen_test.sv
`timescale 1ns/1ps
module ctl_pulse_gen_test;
    localparam int CW = 8;
    localparam int NC = 5;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          wr_en = 1'b0;
    logic [2:0]    wr_sel = '0;
    logic [CW-1:0] wr_data = '0;
    logic          rec_mode = 1'b1;
    logic          ref_in = 1'b0;
    logic          pb_in = 1'b0;
    logic          data_bit = 1'b0;
    logic          pulse_o;
    logic [NC-1:0] match_o;
    logic [CW-1:0] count_o;

    int checks = 0;
    int fails  = 0;
    int strobes_seen = 0;
    logic prev_pulse = 1'b0;
    logic done = 1'b0;
    int exp_slot[$];
    int exp_val[$];
    int act[NC];
    int pend[NC];
    bit pendv[NC];

    always #4 clk = ~clk;

    ctl_pulse_gen #(.CNT_W(CW), .NUM_CMP(NC), .TICK_DIV(4)) uut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .rec_mode(rec_mode), .ref_in(ref_in), .pb_in(pb_in), .data_bit(data_bit),
        .pulse_o(pulse_o), .match_o(match_o), .count_o(count_o)
    );

    task automatic check(input bit ok, input string req, input int got, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: got %0d expected %0d", req, got, exp);
        end
    endtask

    // monitor: pop expected strobes in order and compare
    always @(negedge clk) begin
        if (!rst) begin
            for (int i = 0; i < NC; i++) begin
                if (match_o[i]) begin
                    strobes_seen++;
                    if (exp_slot.size() == 0) begin
                        check(1'b0, "R6 unexpected strobe", i, -1);
                    end else begin
                        int es, ev;
                        es = exp_slot.pop_front();
                        ev = exp_val.pop_front();
                        check(es == i, "R5 slot order", i, es);
                        check(int'(CW'(count_o - 1'b1)) == ev, "R5 strobe count", int'(count_o), ev + 1);
                        if (i == int'(data_bit))
                            check(!pulse_o && prev_pulse, "R8 pulse falls on selected strobe", int'(pulse_o), 0);
                    end
                end
            end
            prev_pulse <= pulse_o;
        end
    end

    task automatic push_all();
        for (int i = 0; i < NC; i++) begin
            exp_slot.push_back(i);
            exp_val.push_back(act[i]);
        end
    endtask

    task automatic push_one(input int i);
        exp_slot.push_back(i);
        exp_val.push_back(act[i]);
    endtask

    task automatic do_write(input int i, input int v);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = 3'(i); wr_data = CW'(v);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic write_now(input int i, input int v);
        do_write(i, v);
        act[i] = v;
        pendv[i] = 1'b0;
    endtask

    task automatic write_later(input int i, input int v);
        do_write(i, v);
        pend[i] = v;
        pendv[i] = 1'b1;
    endtask

    task automatic ref_pulse();
        @(negedge clk);
        ref_in = 1'b1;
        repeat (6) @(negedge clk);
        ref_in = 1'b0;
        for (int i = 0; i < NC; i++)
            if (pendv[i]) begin act[i] = pend[i]; pendv[i] = 1'b0; end
    endtask

    task automatic pb_pulse();
        @(negedge clk);
        pb_in = 1'b1;
        repeat (6) @(negedge clk);
        pb_in = 1'b0;
    endtask

    task automatic wait_cnt(input int v);
        do @(negedge clk); while (int'(count_o) != v);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog: got 1 expected 0");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    initial begin
        int c0;
        for (int i = 0; i < NC; i++) begin act[i] = 0; pend[i] = 0; pendv[i] = 1'b0; end
        repeat (5) @(negedge clk);
        rst = 1'b0;
        // R9 reset state
        check(count_o == '0 && !pulse_o && match_o == '0, "R9 reset state", int'(count_o), 0);
        // R1 counting rate, R9 no strobes before first period
        c0 = int'(count_o);
        repeat (40) @(negedge clk);
        check(int'(count_o) == c0 + 10, "R1 one step per four clocks", int'(count_o), c0 + 10);
        check(strobes_seen == 0, "R9 quiet before first start", strobes_seen, 0);

        write_now(0, 10); write_now(1, 20); write_now(2, 30);
        write_now(3, 40); write_now(4, 50);

        // period 1: record mode, short pulse, immediate write R4
        data_bit = 1'b0;
        ref_pulse();
        check(pulse_o && count_o <= 2, "R2 record restart on ref", int'(count_o), 0);
        wait_cnt(5);
        write_now(2, 35);
        push_all();
        wait_cnt(60);
        check(!pulse_o, "R8 pulse low after short width", int'(pulse_o), 0);
        check(exp_slot.size() == 0, "R4 all matches with new value", exp_slot.size(), 0);

        // wrap without restart R1 R6
        c0 = strobes_seen;
        wait_cnt(255);
        do @(negedge clk); while (count_o == 8'd255);
        check(count_o == '0, "R1 wrap to zero", int'(count_o), 0);
        wait_cnt(60);
        check(strobes_seen == c0, "R6 no repeat after wrap", strobes_seen, c0);
        check(!pulse_o, "R1 wrap keeps period", int'(pulse_o), 0);

        // period 3: mid-period restart R10, long pulse
        data_bit = 1'b1;
        ref_pulse();
        push_one(0); push_one(1);
        wait_cnt(25);
        ref_pulse();
        push_all();
        wait_cnt(60);
        check(exp_slot.size() == 0, "R10 restart rearms all slots", exp_slot.size(), 0);
        check(!pulse_o, "R8 pulse low after long width", int'(pulse_o), 0);

        // rewrite mode R3
        rec_mode = 1'b0;
        data_bit = 1'b0;
        c0 = int'(count_o);
        ref_pulse();
        check(int'(count_o) >= c0, "R3 ref does not restart in rewrite", int'(count_o), c0);
        pb_pulse();
        check(pulse_o && count_o <= 2, "R3 rewrite restart on playback", int'(count_o), 0);
        push_all();
        wait_cnt(25);
        write_later(0, 15);
        wait_cnt(60);
        pb_pulse();
        push_all();
        wait_cnt(60);
        check(exp_slot.size() == 0, "R7 deferred value not yet used", exp_slot.size(), 0);
        c0 = int'(count_o);
        ref_pulse();
        check(int'(count_o) >= c0, "R3 commit edge keeps count", int'(count_o), c0);
        pb_pulse();
        push_all();
        wait_cnt(60);
        check(exp_slot.size() == 0, "R7 deferred value installed", exp_slot.size(), 0);

        // R2 playback ignored in record mode
        rec_mode = 1'b1;
        c0 = int'(count_o);
        pb_pulse();
        check(int'(count_o) >= c0, "R2 playback ignored in record", int'(count_o), c0);

        repeat (10) @(negedge clk);
        check(exp_slot.size() == 0, "R5 scoreboard drained", exp_slot.size(), 0);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule